// File: doc/BRIEF.md
# Stable Reachability Checker for Input/State Machines

This engine takes the transition table of a small input/state machine (each state and input character gives a next state) and works out, per state and held input, the stable state where a chain of transient moves ends. From those stable moves it builds the 0/1 matrix that says which state can be driven to which other state by a non-empty string of input characters. It then answers two questions that a corrective-controller designer asks before building anything. First, can the plant cover a reference model: is every reference reachability entry no greater than the plant entry? Second, can every fault that swaps a stable input for a faulty one be undone, so that the original state can be reached again?

Software, or a boot sequencer, loads three tables through a plain write port: the plant transition table, the reference model's stable next-state table, and a fault mask per input character. It then pulses `start`. A fixed number of cycles later the engine raises `done` for one cycle, and its outputs hold the matrix and the flags until the next run.

Top module: `srx_reach_engine`

## Requirements
- R1: After reset, `done_o`, `exists_o`, `fault_ok_o`, `cyc_err_o` and every bit of `reach_mat` are 0. The plant and reference tables are reset to "every pair stable" (entry (x, v) = x), and all fault masks are reset to empty.
- R2: A write with `wr_en`=1 acts by `wr_kind`. Kind 0 stores `wr_data` as the plant next state for (`wr_row` state, `wr_col` input). Kind 1 stores `wr_data` as the reference stable next state for (`wr_row`, `wr_col`). Kind 2 stores `wr_data` as the fault mask of input `wr_col`, where bit w set means input w is a possible faulty replacement. Kind 3 changes nothing.
- R3: The stable next state of (x, v) is found by applying the plant table N_ST times from x with v held. A pair whose table entry equals its own state is stable.
- R4: Bit i*N_ST+j of `reach_mat` is 1 exactly when some non-empty input string moves state i to state j through stable next states.
- R5: `cyc_err_o` is 1 when some pair (x, v) is still unstable after N_ST applications of the plant table.
- R6: `exists_o` is 1 exactly when every entry of the reference matrix is no greater than the plant entry. The reference matrix is built from the reference table as in R4.
- R7: `fault_ok_o` is 1 exactly when, for every state x, every input v stable at x, and every w in the fault mask of v that is not stable at x, the plant matrix lets x be reached again both from the plant stable next state of (x, w) and from the reference next state of (x, w).
- R8: `done_o` is high for exactly one clock. It is seen in the cycle that follows clock edge 2*N_ST+2, counting the edge that samples `start` as edge 0.
- R9: The outputs change only at the edge that raises `done_o`. A `start` pulse while a run is in progress is ignored.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | Table select: 0 plant, 1 reference, 2 fault mask, 3 none |
| wr_row | input | SW | State index of the written entry |
| wr_col | input | IW | Input character index of the written entry |
| wr_data | input | DW | Next state, or fault mask bits |
| start | input | 1 | Begin a run when idle |
| reach_mat | output | N_ST*N_ST | Plant stable reachability matrix, row-major |
| exists_o | output | 1 | Reference matrix is covered by the plant matrix |
| fault_ok_o | output | 1 | Every masked input fault is recoverable |
| cyc_err_o | output | 1 | Some state/input pair never settled |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that the tables are not written while a run is in progress. The settle and hold properties rely on the plant table staying fixed from `start` to `done_o`. The bench writes tables only between runs. It pokes `start` in the middle of one run to exercise the ignore rule. The bench's reference model resolves chains, builds the closure and evaluates the fault rule with plain integer loops. It then compares `done_o` on every clock against the expected latency.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        WK_PLANT = 2'd0,
        WK_REF   = 2'd1,
        WK_FAULT = 2'd2,
        WK_NONE  = 2'd3
    } wr_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETTLE = 3'd1,
        PH_SEED   = 3'd2,
        PH_CLOSE  = 3'd3,
        PH_EVAL   = 3'd4
    } phase_e;

endpackage

// File: rtl/srx_tables.sv
module srx_tables
    import srx_pkg::*;
#(
    parameter int N_ST = 4,
    parameter int N_IN = 4,
    parameter int SW   = 2,
    parameter int IW   = 2,
    parameter int DW   = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   wr_en,
    input  logic [1:0]                             wr_kind,
    input  logic [SW-1:0]                          wr_row,
    input  logic [IW-1:0]                          wr_col,
    input  logic [DW-1:0]                          wr_data,
    output logic [N_ST-1:0][N_IN-1:0][SW-1:0]      f_tbl,
    output logic [N_ST-1:0][N_IN-1:0][SW-1:0]      sr_tbl,
    output logic [N_IN-1:0][N_IN-1:0]              fmask
);

    logic row_ok, col_ok;

    always_comb begin
        row_ok = (int'(wr_row) < N_ST);
        col_ok = (int'(wr_col) < N_IN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int x = 0; x < N_ST; x++) begin
                for (int v = 0; v < N_IN; v++) begin
                    f_tbl[x][v]  <= SW'(x);
                    sr_tbl[x][v] <= SW'(x);
                end
            end
            fmask <= '0;
        end else if (wr_en && col_ok) begin
            case (wr_kind_e'(wr_kind))
                WK_PLANT: if (row_ok) f_tbl[wr_row][wr_col]  <= wr_data[SW-1:0];
                WK_REF:   if (row_ok) sr_tbl[wr_row][wr_col] <= wr_data[SW-1:0];
                WK_FAULT: fmask[wr_col] <= wr_data[N_IN-1:0];
                default: ;
            endcase
        end
    end

    // R2: the none kind leaves every table untouched
    a_r2_none_kind_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'd3) |=> ($stable(f_tbl) && $stable(sr_tbl) && $stable(fmask)));

endmodule

// File: rtl/srx_settle.sv
module srx_settle #(
    parameter int N_ST = 4,
    parameter int N_IN = 4,
    parameter int SW   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   init,
    input  logic                                   step,
    input  logic [N_ST-1:0][N_IN-1:0][SW-1:0]      f_tbl,
    output logic [N_ST-1:0][N_IN-1:0][SW-1:0]      cur,
    output logic [N_ST-1:0][N_IN-1:0]              stable
);

    always_comb begin
        for (int x = 0; x < N_ST; x++) begin
            for (int v = 0; v < N_IN; v++) begin
                stable[x][v] = (f_tbl[cur[x][v]][v] == cur[x][v]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (init) begin
            for (int x = 0; x < N_ST; x++) begin
                for (int v = 0; v < N_IN; v++) begin
                    cur[x][v] <= SW'(x);
                end
            end
        end else if (step) begin
            for (int x = 0; x < N_ST; x++) begin
                for (int v = 0; v < N_IN; v++) begin
                    cur[x][v] <= f_tbl[cur[x][v]][v];
                end
            end
        end
    end

    for (genvar gx = 0; gx < N_ST; gx++) begin : g_row
        for (genvar gv = 0; gv < N_IN; gv++) begin : g_col
            // R3: once a chain sits on a stable state, further steps keep it there
            a_r3_settled_holds: assert property (@(posedge clk) disable iff (rst)
                (step && !init && stable[gx][gv]) |=> $stable(cur[gx][gv]));
        end
    end

endmodule

// File: rtl/srx_closure.sv
module srx_closure #(
    parameter int N_ST = 4,
    parameter int N_IN = 4,
    parameter int SW   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   seed,
    input  logic                                   close,
    input  logic [N_ST-1:0][N_IN-1:0][SW-1:0]      s_tbl,
    input  logic [N_ST-1:0][N_IN-1:0][SW-1:0]      sr_tbl,
    output logic [N_ST-1:0][N_ST-1:0]              kp,
    output logic [N_ST-1:0][N_ST-1:0]              kr
);

    logic [N_ST-1:0][N_ST-1:0] kp_seed, kr_seed, kp_sq, kr_sq;

    always_comb begin
        for (int i = 0; i < N_ST; i++) begin
            for (int j = 0; j < N_ST; j++) begin
                kp_seed[i][j] = 1'b0;
                kr_seed[i][j] = 1'b0;
                for (int v = 0; v < N_IN; v++) begin
                    if (s_tbl[i][v] == SW'(j))  kp_seed[i][j] = 1'b1;
                    if (sr_tbl[i][v] == SW'(j)) kr_seed[i][j] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_ST; i++) begin
            for (int j = 0; j < N_ST; j++) begin
                kp_sq[i][j] = kp[i][j];
                kr_sq[i][j] = kr[i][j];
                for (int m = 0; m < N_ST; m++) begin
                    kp_sq[i][j] = kp_sq[i][j] | (kp[i][m] & kp[m][j]);
                    kr_sq[i][j] = kr_sq[i][j] | (kr[i][m] & kr[m][j]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kp <= '0;
            kr <= '0;
        end else if (seed) begin
            kp <= kp_seed;
            kr <= kr_seed;
        end else if (close) begin
            kp <= kp_sq;
            kr <= kr_sq;
        end
    end

    // R4: a closure round only adds reachability, never removes it
    a_r4_closure_grows: assert property (@(posedge clk) disable iff (rst)
        close |=> (((kp & $past(kp)) == $past(kp)) && ((kr & $past(kr)) == $past(kr))));

    // R4: seeding and closing never overlap
    a_r4_phase_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seed, close}));

endmodule

// File: rtl/srx_reach_engine.sv
module srx_reach_engine
    import srx_pkg::*;
#(
    parameter int N_ST = 4,
    parameter int N_IN = 4,
    localparam int SW  = (N_ST > 1) ? $clog2(N_ST) : 1,
    localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int DW  = (SW > N_IN) ? SW : N_IN,
    localparam int NM  = N_ST * N_ST
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     wr_kind,
    input  logic [SW-1:0]  wr_row,
    input  logic [IW-1:0]  wr_col,
    input  logic [DW-1:0]  wr_data,
    input  logic           start,
    output logic [NM-1:0]  reach_mat,
    output logic           exists_o,
    output logic           fault_ok_o,
    output logic           cyc_err_o,
    output logic           done_o
);

    localparam int CW = $clog2(N_ST + 1);

    logic [N_ST-1:0][N_IN-1:0][SW-1:0] f_tbl, sr_tbl, s_tbl;
    logic [N_IN-1:0][N_IN-1:0]         fmask;
    logic [N_ST-1:0][N_IN-1:0]         stable;
    logic [N_ST-1:0][N_ST-1:0]         kp, kr;

    phase_e          ph_q;
    logic [CW-1:0]   cnt_q;
    logic            init_c, step_c, seed_c, close_c;
    logic            exists_c, fault_c, err_c;

    srx_tables #(.N_ST(N_ST), .N_IN(N_IN), .SW(SW), .IW(IW), .DW(DW)) u_tables (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .f_tbl(f_tbl), .sr_tbl(sr_tbl), .fmask(fmask)
    );

    srx_settle #(.N_ST(N_ST), .N_IN(N_IN), .SW(SW)) u_settle (
        .clk(clk), .rst(rst), .init(init_c), .step(step_c), .f_tbl(f_tbl),
        .cur(s_tbl), .stable(stable)
    );

    srx_closure #(.N_ST(N_ST), .N_IN(N_IN), .SW(SW)) u_closure (
        .clk(clk), .rst(rst), .seed(seed_c), .close(close_c), .s_tbl(s_tbl),
        .sr_tbl(sr_tbl), .kp(kp), .kr(kr)
    );

    always_comb begin
        init_c  = (ph_q == PH_IDLE) && start;
        step_c  = (ph_q == PH_SETTLE);
        seed_c  = (ph_q == PH_SEED);
        close_c = (ph_q == PH_CLOSE);
    end

    always_comb begin
        exists_c = &(~kr | kp);
        err_c    = ~&stable;
        fault_c  = 1'b1;
        for (int i = 0; i < N_ST; i++) begin
            for (int v = 0; v < N_IN; v++) begin
                if (s_tbl[i][v] == SW'(i)) begin
                    for (int w = 0; w < N_IN; w++) begin
                        if (fmask[v][w] && (s_tbl[i][w] != SW'(i))) begin
                            if (!kp[s_tbl[i][w]][i] || !kp[sr_tbl[i][w]][i])
                                fault_c = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            cnt_q      <= '0;
            done_o     <= 1'b0;
            reach_mat  <= '0;
            exists_o   <= 1'b0;
            fault_ok_o <= 1'b0;
            cyc_err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_SETTLE;
                    cnt_q <= '0;
                end
                PH_SETTLE: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CW'(N_ST - 1)) ph_q <= PH_SEED;
                end
                PH_SEED: begin
                    cnt_q <= '0;
                    ph_q  <= PH_CLOSE;
                end
                PH_CLOSE: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CW'(N_ST - 1)) ph_q <= PH_EVAL;
                end
                PH_EVAL: begin
                    ph_q       <= PH_IDLE;
                    done_o     <= 1'b1;
                    reach_mat  <= kp;
                    exists_o   <= exists_c;
                    fault_ok_o <= fault_c;
                    cyc_err_o  <= err_c;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R8: the result strobe lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: the evaluation phase is always followed by the strobe
    a_r8_done_after_eval: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_EVAL) |=> (done_o && ph_q == PH_IDLE));

    // R9: results move only together with the strobe
    a_r9_results_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (done_o || $stable({reach_mat, exists_o, fault_ok_o, cyc_err_o})));

    // R9: a start seen mid-run does not restart the settle phase
    a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
        (start && ph_q == PH_CLOSE) |=> (ph_q != PH_SETTLE));

endmodule

// File: tb/test_srx_reach_engine.sv
`timescale 1ns/1ps
module test_srx_reach_engine;

    localparam int N  = 4;
    localparam int NI = 4;
    localparam int SW = 2;
    localparam int IW = 2;
    localparam int DW = 4;
    localparam int LAT = 2 * N + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_kind = '0;
    logic [SW-1:0] wr_row = '0;
    logic [IW-1:0] wr_col = '0;
    logic [DW-1:0] wr_data = '0;
    logic start = 1'b0;
    logic [N*N-1:0] reach_mat;
    logic exists_o, fault_ok_o, cyc_err_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int f_m[N][NI];
    int sr_m[N][NI];
    int fm_m[NI];
    int s_m[N][NI];
    int exp_mat, exp_ex, exp_ft, exp_err;

    always #2 clk = ~clk;

    srx_reach_engine #(.N_ST(N), .N_IN(NI)) i_srx_reach_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_row(wr_row),
        .wr_col(wr_col), .wr_data(wr_data), .start(start), .reach_mat(reach_mat),
        .exists_o(exists_o), .fault_ok_o(fault_ok_o), .cyc_err_o(cyc_err_o), .done_o(done_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int kind, int row, int col, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'(kind); wr_row = SW'(row);
        wr_col = IW'(col); wr_data = DW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_all();
        for (int x = 0; x < N; x++)
            for (int v = 0; v < NI; v++) begin
                wr(0, x, v, f_m[x][v]);
                wr(1, x, v, sr_m[x][v]);
            end
        for (int v = 0; v < NI; v++) wr(2, 0, v, fm_m[v]);
    endtask

    function automatic void build_matrix(input int tbl[N][NI], output bit k[N][N]);
        bit t[N][N];
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                k[i][j] = 0;
                for (int v = 0; v < NI; v++) if (tbl[i][v] == j) k[i][j] = 1;
            end
        for (int r = 0; r < N; r++) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    t[i][j] = k[i][j];
                    for (int m = 0; m < N; m++) if (k[i][m] && k[m][j]) t[i][j] = 1;
                end
            k = t;
        end
    endfunction

    task automatic model();
        bit kp[N][N];
        bit kr[N][N];
        exp_err = 0;
        for (int x = 0; x < N; x++)
            for (int v = 0; v < NI; v++) begin
                int c = x;
                for (int k = 0; k < N; k++) c = f_m[c][v];
                s_m[x][v] = c;
                if (f_m[c][v] != c) exp_err = 1;
            end
        build_matrix(s_m, kp);
        build_matrix(sr_m, kr);
        exp_mat = 0;
        exp_ex = 1;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                if (kp[i][j]) exp_mat |= (1 << (i * N + j));
                if (kr[i][j] && !kp[i][j]) exp_ex = 0;
            end
        exp_ft = 1;
        for (int i = 0; i < N; i++)
            for (int v = 0; v < NI; v++)
                if (s_m[i][v] == i)
                    for (int w = 0; w < NI; w++)
                        if (fm_m[v][w] && s_m[i][w] != i)
                            if (!kp[s_m[i][w]][i] || !kp[sr_m[i][w]][i]) exp_ft = 0;
    endtask

    task automatic run(bit poke, bit only_err);
        model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 1; k <= LAT + 2; k++) begin
            @(negedge clk);
            if (poke && k == 3) start = 1'b1;
            if (poke && k == 4) start = 1'b0;
            chk((k == LAT) ? "R8 done at latency" : "R8/R9 done low", int'(done_o), int'(k == LAT));
            if (k == LAT) begin
                chk("R5 cycle flag", int'(cyc_err_o), exp_err);
                if (!only_err) begin
                    chk("R3/R4 reach matrix", int'(reach_mat), exp_mat);
                    chk("R6 exists flag", int'(exists_o), exp_ex);
                    chk("R7 fault flag", int'(fault_ok_o), exp_ft);
                end
            end
        end
        if (!only_err) chk("R9 matrix held", int'(reach_mat), exp_mat);
    endtask

    task automatic base_plant();
        // states 0..3, inputs a=0 b=1 c=2 d=3
        f_m[0] = '{0, 1, 2, 0};
        f_m[1] = '{3, 1, 1, 0};
        f_m[2] = '{2, 2, 2, 1};
        f_m[3] = '{3, 0, 3, 0};
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog actual timeout expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done reset", int'(done_o), 0);
        chk("R1 matrix reset", int'(reach_mat), 0);
        chk("R1 flags reset", int'({exists_o, fault_ok_o, cyc_err_o}), 0);

        // R1/R2 tables reset to all-stable, empty fault masks
        for (int x = 0; x < N; x++)
            for (int v = 0; v < NI; v++) begin f_m[x][v] = x; sr_m[x][v] = x; end
        for (int v = 0; v < NI; v++) fm_m[v] = 0;
        run(0, 0);

        // R3 R4 R6 R7: transient chains, fault b -> {a,d}
        base_plant();
        for (int x = 0; x < N; x++)
            for (int v = 0; v < NI; v++) begin
                int c = x;
                for (int k = 0; k < N; k++) c = f_m[c][v];
                sr_m[x][v] = (x == 2) ? 2 : c;
            end
        fm_m[1] = 4'b1001;
        load_all();
        wr(3, 2, 1, 4'hF);   // R2 kind 3 has no effect
        run(0, 0);
        chk("R3 chain s(2,d)=0 via row 2", (exp_mat >> 8) & 1, 1);

        // R6 R7 negative: state 3 absorbing, plus R9 mid-run start
        f_m[3] = '{3, 3, 3, 3};
        for (int v = 0; v < NI; v++) wr(0, 3, v, 3);
        run(1, 0);
        chk("R6 exists cleared", exp_ex, 0);

        // R5 infinite cycle on input a between states 0 and 1
        base_plant();
        f_m[0][0] = 1; f_m[1][0] = 0;
        for (int x = 0; x < N; x++) for (int v = 0; v < NI; v++) wr(0, x, v, f_m[x][v]);
        run(0, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule